// File: doc/BRIEF.md
# Banked Base-and-Bound Address Relocator

This block relocates and limit-checks a virtual address before it reaches a hierarchical page-table translation stage. Its result is therefore an intermediate address that the paging stage translates further, not a physical address. The relocation registers live in one synchronous memory that holds 32 independent sets of 16 registers. A per-process set index picks the active set, so a context switch is a single index write and no registers are copied.

Each set is organised as eight base/bound pairs. The top three bits of the virtual address select the pair, and the remaining bits form the offset. The offset is checked against the pair's bound, then added to the pair's base. Set zero is reserved for flat addressing: the address passes through unchanged and no fault is raised. A response appears exactly one cycle after each request, and a new request can be accepted every cycle.

Top module: `bb_relocator`

## Requirements
- R1: After reset `rsp_valid_o` and `rsp_fault_o` are low and the active set is zero, so requests made before any set switch are passed through flat.
- R2: Each request with `req_valid_i` high produces exactly one response with `rsp_valid_o` high in the next cycle. Requests in consecutive cycles produce responses in consecutive cycles.
- R3: While the active set is zero, `rsp_addr_o` equals the request address and `rsp_fault_o` stays low, whatever has been written into set zero.
- R4: Bits [31:29] of the virtual address select pair k (0..7) of the active set. Register index 2k of the set is that pair's base, and register index 2k+1 is its bound.
- R5: For a non-zero set, the offset is the virtual address with bits [31:29] cleared. When the offset is below the selected bound, `rsp_addr_o` = base + offset, modulo 2^32, and `rsp_fault_o` is low.
- R6: For a non-zero set, when the offset is greater than or equal to the selected bound, `rsp_fault_o` is high and `rsp_addr_o` is zero. An offset equal to the bound faults; an offset of bound-1 does not.
- R7: A set switch (`ctx_we_i` high with `ctx_set_i`) applies to requests issued from the next cycle on. Different sets give independent results with no reloading.
- R8: A register write (`reg_we_i`) applies to requests issued from the next cycle on. A request issued in the same cycle as the write sees the old value.
- R9: A request issued in the same cycle as a set switch is relocated with the previously active set.
- R10: While `rsp_valid_o` is low, `rsp_addr_o` is zero and `rsp_fault_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_set_i | input | 5 | Set addressed by the write |
| reg_idx_i | input | 4 | Register within the set (even = base, odd = bound) |
| reg_wdata_i | input | 32 | Value written |
| ctx_we_i | input | 1 | Load a new active set index |
| ctx_set_i | input | 5 | New active set index |
| req_valid_i | input | 1 | Request valid |
| req_vaddr_i | input | 32 | Virtual address of the request |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_addr_o | output | 32 | Relocated address, or zero on a fault |
| rsp_fault_o | output | 1 | Offset not below the selected bound |

## Verification
Two kinds of event can land in the same cycle as a request: a software write to the pair the request reads, and a switch of the active set. The bench provokes each collision explicitly. It writes a new base while issuing a request that uses that pair, and it loads a new set index while issuing a request. In both cases the response must reflect the state before the change, and a request in the following cycle must reflect the new state. The bound comparison is tested at offsets of exactly bound and bound-1, and base plus offset is tested in a case that wraps past 2^32.

// File: rtl/bb_reloc_pkg.sv
package bb_reloc_pkg;
  // Storage lanes: even register index goes to base lane, odd to bound lane.
  typedef enum logic {
    LANE_BASE  = 1'b0,
    LANE_BOUND = 1'b1
  } lane_e;

  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/bb_set_mem.sv
module bb_set_mem #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SET_W  = 5,
  parameter int unsigned PAIR_W = 3
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [SET_W-1:0]  wset_i,
  input  logic [PAIR_W:0]   widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [SET_W-1:0]  rset_i,
  input  logic [PAIR_W-1:0] rpair_i,
  output logic [DATA_W-1:0] base_o,
  output logic [DATA_W-1:0] bound_o
);
  import bb_reloc_pkg::*;

  localparam int unsigned ROW_W = SET_W + PAIR_W;
  localparam int unsigned DEPTH = 1 << ROW_W;

  logic [ROW_W-1:0]  wrow, rrow;
  logic [DATA_W-1:0] lane_q [NUM_LANES];

  assign wrow = {wset_i, widx_i[PAIR_W:1]};
  assign rrow = {rset_i, rpair_i};

  for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic              lane_we;

    assign lane_we = we_i && (widx_i[0] == 1'(ln));

    // Read-before-write: a same-edge read returns the old word.
    always_ff @(posedge clk_i) begin
      if (lane_we) mem[wrow] <= wdata_i;
      if (re_i)    rd_q      <= mem[rrow];
    end

    assign lane_q[ln] = rd_q;
  end

  assign base_o  = lane_q[int'(LANE_BASE)];
  assign bound_o = lane_q[int'(LANE_BOUND)];
endmodule

// File: rtl/bb_ctx_reg.sv
module bb_ctx_reg #(
  parameter int unsigned SET_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SET_W-1:0] set_i,
  output logic [SET_W-1:0] active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   active_o <= '0;
    else if (we_i) active_o <= set_i;
  end

  // R7: index changes only through a switch, one edge later
  p_ctx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(active_o));
endmodule

// File: rtl/bb_req_stage.sv
module bb_req_stage #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              flat_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic              valid_o,
  output logic              flat_o,
  output logic [ADDR_W-1:0] vaddr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      flat_o  <= 1'b1;
      vaddr_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        flat_o  <= flat_i;
        vaddr_o <= vaddr_i;
      end
    end
  end

  // R2: request and response slots stay paired
  p_req_to_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
endmodule

// File: rtl/bb_resp_calc.sv
module bb_resp_calc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              valid_i,
  input  logic              flat_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] bound_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic              rsp_fault_o
);
  localparam int unsigned OFS_W = ADDR_W - SEL_W;

  logic [ADDR_W-1:0] offset;
  logic              over;

  assign offset = {{SEL_W{1'b0}}, vaddr_i[OFS_W-1:0]};
  assign over   = offset >= bound_i;

  always_comb begin
    rsp_valid_o = valid_i;
    rsp_fault_o = 1'b0;
    rsp_addr_o  = '0;
    if (valid_i) begin
      if (flat_i) begin
        rsp_addr_o = vaddr_i;
      end else if (over) begin
        rsp_fault_o = 1'b1;
      end else begin
        rsp_addr_o = base_i + offset;
      end
    end
  end
endmodule

// File: rtl/bb_relocator.sv
module bb_relocator #(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned NUM_SETS     = 32,
  parameter int unsigned REGS_PER_SET = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_we_i,
  input  logic [$clog2(NUM_SETS)-1:0]     reg_set_i,
  input  logic [$clog2(REGS_PER_SET)-1:0] reg_idx_i,
  input  logic [ADDR_W-1:0]             reg_wdata_i,
  input  logic                          ctx_we_i,
  input  logic [$clog2(NUM_SETS)-1:0]     ctx_set_i,
  input  logic                          req_valid_i,
  input  logic [ADDR_W-1:0]             req_vaddr_i,
  output logic                          rsp_valid_o,
  output logic [ADDR_W-1:0]             rsp_addr_o,
  output logic                          rsp_fault_o
);
  localparam int unsigned SET_W  = $clog2(NUM_SETS);
  localparam int unsigned IDX_W  = $clog2(REGS_PER_SET);
  localparam int unsigned PAIR_W = IDX_W - 1;

  logic [SET_W-1:0]  active_set;
  logic              in_flat;
  logic              st_valid, st_flat;
  logic [ADDR_W-1:0] st_vaddr;
  logic [ADDR_W-1:0] rd_base, rd_bound;

  bb_ctx_reg #(.SET_W(SET_W)) u_ctx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctx_we_i),
    .set_i    (ctx_set_i),
    .active_o (active_set)
  );

  assign in_flat = (active_set == '0);

  bb_set_mem #(.DATA_W(ADDR_W), .SET_W(SET_W), .PAIR_W(PAIR_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (reg_we_i),
    .wset_i  (reg_set_i),
    .widx_i  (reg_idx_i),
    .wdata_i (reg_wdata_i),
    .re_i    (req_valid_i && !in_flat),
    .rset_i  (active_set),
    .rpair_i (req_vaddr_i[ADDR_W-1 -: PAIR_W]),
    .base_o  (rd_base),
    .bound_o (rd_bound)
  );

  bb_req_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .flat_i  (in_flat),
    .vaddr_i (req_vaddr_i),
    .valid_o (st_valid),
    .flat_o  (st_flat),
    .vaddr_o (st_vaddr)
  );

  bb_resp_calc #(.ADDR_W(ADDR_W), .SEL_W(PAIR_W)) u_calc (
    .valid_i     (st_valid),
    .flat_i      (st_flat),
    .vaddr_i     (st_vaddr),
    .base_i      (rd_base),
    .bound_i     (rd_bound),
    .rsp_valid_o (rsp_valid_o),
    .rsp_addr_o  (rsp_addr_o),
    .rsp_fault_o (rsp_fault_o)
  );

  // R3: flat set passes address through, never faults
  p_flat_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && active_set == '0) |=>
      (rsp_addr_o == $past(req_vaddr_i) && !rsp_fault_o));

  // R7: switch makes the new set active for the next request
  p_ctx_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_we_i |=> active_set == $past(ctx_set_i));

  // R10: idle response slot is quiet
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_fault_o && rsp_addr_o == '0));

  // R6: a fault never leaks an address
  p_fault_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_valid_o && rsp_addr_o == '0));
endmodule

// File: tb/sim_bb_relocator.sv
`timescale 1ns/1ps
module sim_bb_relocator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_set = '0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic        ctx_we = 1'b0;
  logic [4:0]  ctx_set = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        rsp_fault;

  int n_run = 0;
  int n_fail = 0;

  logic [31:0] m_base  [32][8];
  logic [31:0] m_bound [32][8];
  logic [4:0]  m_active = '0;

  always #2.5 clk = ~clk;

  bb_relocator u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_set_i(reg_set), .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata),
    .ctx_we_i(ctx_we), .ctx_set_i(ctx_set),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr), .rsp_fault_o(rsp_fault)
  );

  function automatic logic [32:0] model(input logic [4:0] s, input logic [31:0] va);
    logic [31:0] ofs;
    logic [2:0]  k;
    k   = va[31:29];
    ofs = {3'b0, va[28:0]};
    if (s == 0) return {1'b0, va};
    if (ofs >= m_bound[s][k]) return {1'b1, 32'h0};
    return {1'b0, m_base[s][k] + ofs};
  endfunction

  task automatic check(input string req, input logic v, input logic [31:0] a, input logic f,
                       input logic ev, input logic [31:0] ea, input logic ef);
    n_run++;
    if (v !== ev || a !== ea || f !== ef) begin
      n_fail++;
      $display("FAIL %s: got v=%0b a=%h f=%0b exp v=%0b a=%h f=%0b", req, v, a, f, ev, ea, ef);
    end
  endtask

  task automatic wr(input logic [4:0] s, input logic [3:0] i, input logic [31:0] d);
    reg_we = 1'b1; reg_set = s; reg_idx = i; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (i[0]) m_bound[s][i[3:1]] = d; else m_base[s][i[3:1]] = d;
  endtask

  task automatic switch_set(input logic [4:0] s);
    ctx_we = 1'b1; ctx_set = s;
    @(negedge clk);
    ctx_we = 1'b0;
    m_active = s;
  endtask

  task automatic one_req(input string req, input logic [31:0] va);
    logic [32:0] e;
    e = model(m_active, va);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, rsp_valid, rsp_addr, rsp_fault, 1'b1, e[31:0], e[32]);
  endtask

  task automatic t_reset;
    // R1: quiet outputs after reset, R10 idle zeros
    check("R1", rsp_valid, rsp_addr, rsp_fault, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    check("R10", rsp_valid, rsp_addr, rsp_fault, 1'b0, 32'h0, 1'b0);
    // R1: default set zero gives flat result
    one_req("R1", 32'hE123_4567);
  endtask

  task automatic t_load;
    for (int s = 1; s < 3; s++)
      for (int k = 0; k < 8; k++) begin
        wr(5'(s), 4'(2*k),     32'h4000_0000 * s + 32'h0010_0000 * k);
        wr(5'(s), 4'(2*k + 1), 32'h0000_1000 * (k + 1) * s);
      end
    wr(5'd2, 4'd14, 32'hFFFF_FF00);
    wr(5'd2, 4'd15, 32'h0000_1000);
    wr(5'd0, 4'd0, 32'h1234_0000);
    wr(5'd0, 4'd1, 32'h0000_0001);
  endtask

  task automatic t_flat;
    // R3: set zero ignores its stored pairs
    one_req("R3", 32'h0000_0040);
    one_req("R3", 32'h1FFF_FFFF);
    one_req("R3", 32'hFFFF_FFFF);
  endtask

  task automatic t_pairs;
    switch_set(5'd1);
    // R4/R5: every pair selected by top bits
    for (int k = 0; k < 8; k++) one_req("R4", {3'(k), 29'h80});
    one_req("R5", 32'h2000_0123);
  endtask

  task automatic t_bound;
    // R6: pair 3 of set 1 has bound 0x4000
    one_req("R6", {3'd3, 29'h3FFF});
    one_req("R6", {3'd3, 29'h4000});
    one_req("R6", {3'd0, 29'h1FFF_FFFF});
    // R5: wrap of base + offset in set 2 pair 7
    switch_set(5'd2);
    one_req("R5", {3'd7, 29'h200});
  endtask

  task automatic t_back_to_back;
    logic [32:0] e1, e2;
    e1 = model(m_active, {3'd1, 29'h10});
    e2 = model(m_active, {3'd2, 29'h5000});
    req_valid = 1'b1; req_vaddr = {3'd1, 29'h10};
    @(negedge clk);
    check("R2", rsp_valid, rsp_addr, rsp_fault, 1'b1, e1[31:0], e1[32]);
    req_vaddr = {3'd2, 29'h5000};
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", rsp_valid, rsp_addr, rsp_fault, 1'b1, e2[31:0], e2[32]);
    @(negedge clk);
    check("R10", rsp_valid, rsp_addr, rsp_fault, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_switch_collide;
    logic [32:0] e_old;
    // R9: request alongside a switch uses the old set (2)
    e_old = model(m_active, {3'd4, 29'h20});
    ctx_we = 1'b1; ctx_set = 5'd1;
    req_valid = 1'b1; req_vaddr = {3'd4, 29'h20};
    @(negedge clk);
    ctx_we = 1'b0; req_valid = 1'b0;
    m_active = 5'd1;
    check("R9", rsp_valid, rsp_addr, rsp_fault, 1'b1, e_old[31:0], e_old[32]);
    // R7: next request sees set 1
    one_req("R7", {3'd4, 29'h20});
    switch_set(5'd0);
    one_req("R7", {3'd4, 29'h20});
  endtask

  task automatic t_write_collide;
    logic [32:0] e_old;
    switch_set(5'd1);
    // R8: base rewrite in the same cycle as a request that reads it
    e_old = model(m_active, {3'd0, 29'h10});
    reg_we = 1'b1; reg_set = 5'd1; reg_idx = 4'd0; reg_wdata = 32'h0AB0_0000;
    req_valid = 1'b1; req_vaddr = {3'd0, 29'h10};
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0;
    m_base[1][0] = 32'h0AB0_0000;
    check("R8", rsp_valid, rsp_addr, rsp_fault, 1'b1, e_old[31:0], e_old[32]);
    one_req("R8", {3'd0, 29'h10});
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_flat();
    t_pairs();
    t_bound();
    t_back_to_back();
    t_switch_collide();
    t_write_collide();
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule